// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Transmit-End Status

This block turns bytes into an asynchronous serial line. Two sources can load the transmit holding register. Software writes the data and then releases it by clearing the holding-empty flag, following a read-then-write rule. A DMA-style port loads the data and releases it in a single strobe. On each bit-period strobe from an external baud generator, a shift engine sends a start bit, the data bits least significant bit first, an optional parity bit and one or two stop bits.

The block hands bytes from the holding register to the shift engine. When a character ends and another byte is waiting, that byte is launched on the same bit boundary, so no idle bit appears between the two frames. When a character ends and nothing is waiting, a read-only transmit-end flag goes high to report that the line is idle. The flag has no write path. It falls only as a side effect of a byte being released into the holding register. While transmit enable is low, the line rests high and the flag is held at 1.

Top module: `async_tx_endflag`

## Requirements
- R1: After a synchronous reset, `txd` is 1, `tdr_empty` is 1 and `tx_end` is 1.
- R2: `tx_end` has no write path. A status write of any value, with or without a preceding read, leaves it unchanged unless that write releases data under R7.
- R3: While `tx_en` is 0, `tx_end` is held at 1 and `txd` is 1 from the next cycle, and a frame in progress is abandoned. A DMA write made while disabled does not lower `tx_end`.
- R4: A frame is sent as a start bit of 0, then DATA_W data bits least significant first, then a parity bit when `par_en` is 1, then one stop bit of 1, or two when `two_stop` is 1. Each bit lasts from one `baud_tick` to the next.
- R5: The parity bit is the XOR of the data bits when `par_odd` is 0 (even parity), and its inverse when `par_odd` is 1.
- R6: `tx_end` stays 0 while a frame that began with it at 0 is on the line. It rises at the `baud_tick` edge that ends the final stop bit if `tdr_empty` is still 1 at that edge, unless a release lands on the same edge.
- R7: A status read (`st_rd`) while `tdr_empty` is 1 arms a clear. The next status write (`st_wr`) with `st_wr_empty` = 0 then drops `tdr_empty` and `tx_end` to 0 in the following cycle. The same write without a prior arming read, a write of 1, or a `cpu_wr` data write leaves both flags unchanged. Any status write disarms the clear.
- R8: A `dma_wr` loads the holding register and drops `tdr_empty` and `tx_end` to 0 in the following cycle.
- R9: If `tdr_empty` is 0 at the edge that ends a frame, the waiting byte's start bit begins at that same edge, with no idle bit, and `tdr_empty` returns to 1 there.
- R10: From idle, a released byte is taken at the next `baud_tick` edge: `txd` falls to the start bit and `tdr_empty` returns to 1 on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable |
| baud_tick | input | 1 | One-cycle strobe marking each bit boundary |
| par_en | input | 1 | Append a parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| two_stop | input | 1 | 1 sends two stop bits |
| cpu_wr | input | 1 | Software write of the holding register |
| cpu_wdata | input | DATA_W | Software write data |
| dma_wr | input | 1 | DMA-style load that also releases the byte |
| dma_wdata | input | DATA_W | DMA-style write data |
| st_rd | input | 1 | Status read strobe (arms the empty-flag clear) |
| st_wr | input | 1 | Status write strobe |
| st_wr_empty | input | 1 | Value written to the empty flag |
| txd | output | 1 | Serial line, idle high |
| tdr_empty | output | 1 | Holding register has no unsent byte |
| tx_end | output | 1 | Read-only flag: line idle with nothing left to send |

## Verification
The bench aims at the frame boundary. A byte released in the middle of a frame must follow with no idle bit; a design that waited one bit period would insert a high bit, and one that dropped the byte would leave the queue unsent. It checks the exact edge where `tx_end` rises, where an early flag shows up during the stop bits and a missing one stays low on an idle line. It also checks release attempts without an arming read and writes aimed at `tx_end`, which a design with a write path would let through. Finally it disables transmission in the middle of a frame and makes a DMA load while disabled, where a design that lets the clear win over the disable force would report the line busy.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

  typedef enum logic [2:0] {
    TXS_IDLE,
    TXS_START,
    TXS_DATA,
    TXS_PARITY,
    TXS_STOP1,
    TXS_STOP2
  } txs_e;

  typedef struct packed {
    logic par_en;
    logic par_odd;
    logic two_stop;
  } frame_cfg_t;

endpackage

// File: rtl/atx_holding.sv
module atx_holding #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              dma_wr,
  input  logic [DATA_W-1:0] dma_wdata,
  input  logic              st_rd,
  input  logic              st_wr,
  input  logic              st_wr_empty,
  input  logic              take,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_valid,
  output logic              empty_flag,
  output logic              sw_release
);

  logic              empty_q;
  logic              armed_q;
  logic [DATA_W-1:0] data_q;

  // software release: write of 0 after a read that saw the flag set
  assign sw_release = st_wr && !st_wr_empty && armed_q && empty_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      empty_q <= 1'b1;
      armed_q <= 1'b0;
      data_q  <= '0;
    end else begin
      if (dma_wr) begin
        data_q <= dma_wdata;
      end else if (cpu_wr) begin
        data_q <= cpu_wdata;
      end

      // a DMA load always leaves a valid byte, even if the old one
      // is being taken on the same edge
      if (dma_wr) begin
        empty_q <= 1'b0;
      end else if (take) begin
        empty_q <= 1'b1;
      end else if (sw_release) begin
        empty_q <= 1'b0;
      end

      if (st_wr) begin
        armed_q <= 1'b0;
      end else if (st_rd && empty_q) begin
        armed_q <= 1'b1;
      end
    end
  end

  assign hold_data  = data_q;
  assign hold_valid = !empty_q;
  assign empty_flag = empty_q;

endmodule

// File: rtl/atx_serializer.sv
module atx_serializer
  import async_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              baud_tick,
  input  frame_cfg_t        cfg,
  input  logic              hold_valid,
  input  logic [DATA_W-1:0] hold_data,
  output logic              take,
  output logic              idle_set,
  output logic              txd
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  txs_e              state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] shreg_q;
  logic              pbit_q;
  logic              txd_q;

  logic finishing;
  logic slot_free;

  assign finishing = ((state_q == TXS_STOP1) && !cfg.two_stop) || (state_q == TXS_STOP2);
  assign slot_free = (state_q == TXS_IDLE) || finishing;
  assign take      = tx_en && baud_tick && slot_free && hold_valid;
  assign idle_set  = tx_en && baud_tick && finishing && !hold_valid;

  always_ff @(posedge clk) begin
    if (rst || !tx_en) begin
      state_q <= TXS_IDLE;
      cnt_q   <= '0;
      shreg_q <= '0;
      pbit_q  <= 1'b0;
      txd_q   <= 1'b1;
    end else if (baud_tick) begin
      if (take) begin
        shreg_q <= hold_data;
        pbit_q  <= (^hold_data) ^ cfg.par_odd;
        txd_q   <= 1'b0;
        state_q <= TXS_START;
      end else begin
        unique case (state_q)
          TXS_IDLE: begin
            txd_q <= 1'b1;
          end
          TXS_START: begin
            txd_q   <= shreg_q[0];
            shreg_q <= shreg_q >> 1;
            cnt_q   <= '0;
            state_q <= TXS_DATA;
          end
          TXS_DATA: begin
            if (cnt_q == LAST_BIT) begin
              if (cfg.par_en) begin
                txd_q   <= pbit_q;
                state_q <= TXS_PARITY;
              end else begin
                txd_q   <= 1'b1;
                state_q <= TXS_STOP1;
              end
            end else begin
              txd_q   <= shreg_q[0];
              shreg_q <= shreg_q >> 1;
              cnt_q   <= cnt_q + 1'b1;
            end
          end
          TXS_PARITY: begin
            txd_q   <= 1'b1;
            state_q <= TXS_STOP1;
          end
          TXS_STOP1: begin
            txd_q   <= 1'b1;
            state_q <= cfg.two_stop ? TXS_STOP2 : TXS_IDLE;
          end
          TXS_STOP2: begin
            txd_q   <= 1'b1;
            state_q <= TXS_IDLE;
          end
          default: begin
            txd_q   <= 1'b1;
            state_q <= TXS_IDLE;
          end
        endcase
      end
    end
  end

  assign txd = txd_q;

endmodule

// File: rtl/atx_end_status.sv
module atx_end_status (
  input  logic clk,
  input  logic rst,
  input  logic tx_en,
  input  logic idle_set,
  input  logic dma_wr,
  input  logic sw_release,
  output logic end_flag
);

  logic end_q;

  always_ff @(posedge clk) begin
    if (rst || !tx_en) begin
      end_q <= 1'b1;
    end else if (dma_wr || sw_release) begin
      end_q <= 1'b0;
    end else if (idle_set) begin
      end_q <= 1'b1;
    end
  end

  assign end_flag = end_q;

endmodule

// File: rtl/async_tx_endflag.sv
module async_tx_endflag
  import async_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              baud_tick,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              two_stop,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              dma_wr,
  input  logic [DATA_W-1:0] dma_wdata,
  input  logic              st_rd,
  input  logic              st_wr,
  input  logic              st_wr_empty,
  output logic              txd,
  output logic              tdr_empty,
  output logic              tx_end
);

  frame_cfg_t        cfg;
  logic [DATA_W-1:0] hold_data;
  logic              hold_valid;
  logic              take;
  logic              idle_set;
  logic              sw_release;

  assign cfg = '{par_en: par_en, par_odd: par_odd, two_stop: two_stop};

  atx_holding #(.DATA_W(DATA_W)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .cpu_wr     (cpu_wr),
    .cpu_wdata  (cpu_wdata),
    .dma_wr     (dma_wr),
    .dma_wdata  (dma_wdata),
    .st_rd      (st_rd),
    .st_wr      (st_wr),
    .st_wr_empty(st_wr_empty),
    .take       (take),
    .hold_data  (hold_data),
    .hold_valid (hold_valid),
    .empty_flag (tdr_empty),
    .sw_release (sw_release)
  );

  atx_serializer #(.DATA_W(DATA_W)) u_ser (
    .clk       (clk),
    .rst       (rst),
    .tx_en     (tx_en),
    .baud_tick (baud_tick),
    .cfg       (cfg),
    .hold_valid(hold_valid),
    .hold_data (hold_data),
    .take      (take),
    .idle_set  (idle_set),
    .txd       (txd)
  );

  atx_end_status u_end (
    .clk       (clk),
    .rst       (rst),
    .tx_en     (tx_en),
    .idle_set  (idle_set),
    .dma_wr    (dma_wr),
    .sw_release(sw_release),
    .end_flag  (tx_end)
  );

endmodule

// File: rtl/async_tx_endflag_checks.sv
module async_tx_endflag_checks (
  input logic clk,
  input logic rst,
  input logic tx_en,
  input logic baud_tick,
  input logic dma_wr,
  input logic st_wr,
  input logic txd,
  input logic tdr_empty,
  input logic tx_end
);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (txd && tdr_empty && tx_end));

  assert_disabled_forces_R3: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> (tx_end && txd));

  // R2: the flag only falls as a side effect of a release strobe
  assert_end_fall_cause_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_end) |-> ($past(dma_wr) || $past(st_wr)));

  assert_end_rise_cause_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_end) |-> ($past(!tx_en) || $past(baud_tick)));

  assert_empty_rise_on_tick_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(tdr_empty) |-> ($past(baud_tick) && $past(tx_en)));

  assert_start_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(txd) |-> $past(baud_tick));

endmodule

bind async_tx_endflag async_tx_endflag_checks u_checks (
  .clk      (clk),
  .rst      (rst),
  .tx_en    (tx_en),
  .baud_tick(baud_tick),
  .dma_wr   (dma_wr),
  .st_wr    (st_wr),
  .txd      (txd),
  .tdr_empty(tdr_empty),
  .tx_end   (tx_end)
);

// File: tb/async_tx_endflag_bench.sv
module async_tx_endflag_bench;

  localparam int DW = 8;
  localparam int TICK_DIV = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_en = 1'b0;
  logic baud_tick = 1'b0;
  logic par_en = 1'b0;
  logic par_odd = 1'b0;
  logic two_stop = 1'b0;
  logic cpu_wr = 1'b0;
  logic dma_wr = 1'b0;
  logic st_rd = 1'b0;
  logic st_wr = 1'b0;
  logic st_wr_empty = 1'b1;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] dma_wdata = '0;
  wire txd, tdr_empty, tx_end;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int last_clr = -10;
  int frames = 0;
  int pushed = 0;
  bit mon_abort = 1'b0;
  bit mon_busy = 1'b0;
  bit chk_end = 1'b1;
  logic tick_q = 1'b0;
  logic [DW-1:0] exp_q[$];

  async_tx_endflag #(.DATA_W(DW)) u_async_tx_endflag (
    .clk(clk), .rst(rst), .tx_en(tx_en), .baud_tick(baud_tick),
    .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .dma_wr(dma_wr), .dma_wdata(dma_wdata),
    .st_rd(st_rd), .st_wr(st_wr), .st_wr_empty(st_wr_empty),
    .txd(txd), .tdr_empty(tdr_empty), .tx_end(tx_end)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc    <= cyc + 1;
    tick_q <= baud_tick;
  end

  initial begin
    int d = 0;
    forever begin
      @(negedge clk);
      baud_tick = (d == TICK_DIV - 1);
      d = (d + 1) % TICK_DIV;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit par_of(input logic [DW-1:0] d, input bit odd);
    return (^d) ^ odd;
  endfunction

  task automatic push_dma(input logic [DW-1:0] d);
    @(negedge clk);
    dma_wr = 1'b1; dma_wdata = d;
    exp_q.push_back(d); pushed++;
    last_clr = cyc;
    @(negedge clk);
    dma_wr = 1'b0;
  endtask

  task automatic push_cpu(input logic [DW-1:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0; st_rd = 1'b1;
    @(negedge clk);
    st_rd = 1'b0; st_wr = 1'b1; st_wr_empty = 1'b0;
    exp_q.push_back(d); pushed++;
    last_clr = cyc;
    @(negedge clk);
    st_wr = 1'b0; st_wr_empty = 1'b1;
  endtask

  task automatic settle();
    while (!(tdr_empty && tx_end && !mon_busy && exp_q.size() == 0)) @(negedge clk);
    repeat (2 * TICK_DIV) @(negedge clk);
  endtask

  // line monitor: decodes txd once per bit period
  initial begin
    int st = 0;
    int cnt = 0;
    bit bound = 1'b0;
    bit prev_empty = 1'b1;
    bit fin;
    logic [DW-1:0] acc = '0;
    forever begin
      @(negedge clk);
      #1;
      fin = 1'b0;
      if (mon_abort) begin
        mon_abort = 1'b0;
        if (st != 0 && exp_q.size() > 0) void'(exp_q.pop_front());
        st = 0; bound = 1'b0;
      end else if (tick_q) begin
        case (st)
          0: begin
            if (txd == 1'b0) begin
              if (bound) begin
                chk(prev_empty == 1'b0, "R9 start only with pending byte", prev_empty, 0);
                if (chk_end) chk(tx_end == 1'b0, "R9 end stays low back-to-back", tx_end, 0);
              end
              chk(tdr_empty == 1'b1, "R10 empty set at launch", tdr_empty, 1);
              st = 1; cnt = 0;
            end else if (bound) begin
              chk(prev_empty == 1'b1, "R9 pending byte launched without gap", prev_empty, 1);
              if (chk_end)
                chk(tx_end == (last_clr != cyc - 1), "R6 end flag at final edge",
                    tx_end, int'(last_clr != cyc - 1));
            end
            bound = 1'b0;
          end
          1: begin
            acc[cnt] = txd; cnt++;
            if (cnt == DW) st = par_en ? 2 : 3;
          end
          2: begin
            chk(txd == par_of(acc, par_odd), "R5 parity bit", txd, par_of(acc, par_odd));
            st = 3;
          end
          3, 4: begin
            chk(txd == 1'b1, "R4 stop bit", txd, 1);
            if (chk_end) chk(tx_end == 1'b0, "R6 end low during frame", tx_end, 0);
            if (st == 3 && two_stop) st = 4;
            else fin = 1'b1;
          end
          default: st = 0;
        endcase
        if (fin) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R4 unexpected frame", acc, -1);
          end else begin
            logic [DW-1:0] e;
            e = exp_q.pop_front();
            chk(acc == e, "R4 frame data", acc, e);
          end
          frames++;
          st = 0; bound = 1'b1;
        end
      end
      mon_busy = (st != 0);
      prev_empty = tdr_empty;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(txd == 1'b1 && tdr_empty == 1'b1 && tx_end == 1'b1, "R1 flags in reset",
        {txd, tdr_empty, tx_end}, 7);
    tx_en = 1'b1;
    rst = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R1 txd after reset", txd, 1);
    chk(tdr_empty == 1'b1, "R1 empty after reset", tdr_empty, 1);
    chk(tx_end == 1'b1, "R1 end after reset", tx_end, 1);

    // release attempt with no arming read
    st_wr = 1'b1; st_wr_empty = 1'b0;
    @(negedge clk);
    st_wr = 1'b0; st_wr_empty = 1'b1;
    @(negedge clk);
    chk(tdr_empty == 1'b1, "R7 unarmed clear ignored", tdr_empty, 1);
    chk(tx_end == 1'b1, "R2 end unchanged by status write", tx_end, 1);
    cpu_wr = 1'b1; cpu_wdata = 8'h96;
    @(negedge clk);
    cpu_wr = 1'b0;
    @(negedge clk);
    chk(tdr_empty == 1'b1 && tx_end == 1'b1, "R7 data write leaves flags", {tdr_empty, tx_end}, 3);
    st_rd = 1'b1;
    @(negedge clk);
    st_rd = 1'b0; st_wr = 1'b1; st_wr_empty = 1'b1;
    @(negedge clk);
    st_wr = 1'b0;
    @(negedge clk);
    chk(tdr_empty == 1'b1, "R7 write of one ignored", tdr_empty, 1);
    chk(tx_end == 1'b1, "R2 end ignores write", tx_end, 1);
    st_rd = 1'b1;
    @(negedge clk);
    st_rd = 1'b0; st_wr = 1'b1; st_wr_empty = 1'b0;
    exp_q.push_back(8'h96); pushed++;
    last_clr = cyc;
    @(negedge clk);
    st_wr = 1'b0; st_wr_empty = 1'b1;
    chk(tdr_empty == 1'b0, "R7 armed clear drops empty", tdr_empty, 0);
    chk(tx_end == 1'b0, "R7 armed clear drops end", tx_end, 0);
    settle();

    // DMA release and back-to-back frames
    push_dma(8'h5A);
    chk(tdr_empty == 1'b0, "R8 dma drops empty", tdr_empty, 0);
    chk(tx_end == 1'b0, "R8 dma drops end", tx_end, 0);
    while (!tdr_empty) @(negedge clk);
    push_dma(8'hC3);
    settle();

    // parity and stop-bit variants
    par_en = 1'b1; par_odd = 1'b0;
    push_dma(8'h07);
    settle();
    par_odd = 1'b1;
    push_dma(8'h07);
    while (!tdr_empty) @(negedge clk);
    push_dma(8'h80);
    settle();
    two_stop = 1'b1;
    push_dma(8'hFF);
    while (!tdr_empty) @(negedge clk);
    push_dma(8'h00);
    settle();
    par_en = 1'b0;

    // disable mid-frame
    push_dma(8'hA5);
    repeat (6 * TICK_DIV) @(negedge clk);
    tx_en = 1'b0; mon_abort = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1, "R3 line high when disabled", txd, 1);
    chk(tx_end == 1'b1, "R3 end forced when disabled", tx_end, 1);
    push_dma(8'h3C);
    chk(tx_end == 1'b1, "R3 dma while disabled keeps end", tx_end, 1);
    chk(tdr_empty == 1'b0, "R8 dma while disabled drops empty", tdr_empty, 0);
    repeat (3 * TICK_DIV) @(negedge clk);
    chk(txd == 1'b1, "R3 no frame while disabled", txd, 1);
    chk_end = 1'b0;
    tx_en = 1'b1;
    settle();
    chk_end = 1'b1;

    // random traffic
    for (int i = 0; i < 60; i++) begin
      if (i % 10 == 9) begin
        settle();
        par_en = 1'($urandom_range(0, 1));
        par_odd = 1'($urandom_range(0, 1));
        two_stop = 1'($urandom_range(0, 1));
      end
      repeat ($urandom_range(0, 40)) @(negedge clk);
      while (!tdr_empty) @(negedge clk);
      if ($urandom_range(0, 1) == 1) push_dma(DW'($urandom));
      else push_cpu(DW'($urandom));
    end
    settle();
    chk(exp_q.size() == 0, "R4 every byte sent", exp_q.size(), 0);
    chk(frames == pushed - 1, "R4 frame count", frames, pushed - 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule